// File: doc/BRIEF.md
# Repeat and Loop Counter Sequencer

This block keeps the two iteration counters of an instruction dock and makes the completion decision for each pass of the instruction at the head of the queue. On every cycle the surrounding dock raises the execute strobe. The block then reports exactly one of three outcomes. The instruction either runs again in place (repeat), is put back into the queue (reloop), or leaves the queue (retire).

The dock supplies the decoded instruction class, the result of the instruction's predicate, its decrement-loop bit, a two-bit counter selector, a short literal and the current data latch word. The block loads the counters when it sees counter-load instructions. It steps the repeat counter on repeat passes and applies the decrement-loop bit when an instruction completes. For the counter-copy instructions it presents a merged data word whose low bits carry a counter value.

The repeat counter has a separate infinity flag next to its count. While that flag is set, repeat passes never use up the count.

Top module: `rlseq_top`

## Requirements
- R1: After reset the repeat count, the infinity flag and the loop count are all zero. While the strobe is low, no decision output and no copy request is active.
- R2: While `exec_i` is low, no decision or copy output is asserted and both counters hold their values.
- R3: A repeat-load instruction (class 3) whose predicate holds changes the repeat counter according to `sel_i`:
  - `00` loads the low CNT_W bits of `data_i` and clears infinity.
  - `10` loads `lit_i` and clears infinity.
  - `11` sets infinity, and the count field then reads as all ones.
  - `01` leaves the counter unchanged.
- R4: A loop-load instruction (class 4) whose predicate holds loads the loop counter. When `sel_i[0]` is 0 the value is the low CNT_W bits of `data_i`; when it is 1 the value is `lit_i`.
- R5: A send instruction (class 0) whose predicate holds asserts `repeat_o` when the repeat count is nonzero or infinity is set. In that case a finite count drops by one on the next edge and an infinite count stays infinite.
- R6: Every class other than send, and any send whose predicate fails, asserts no `repeat_o` and leaves the repeat counter unchanged, except for a repeat-load as in R3.
- R7: On each strobe exactly one of `repeat_o`, `reloop_o` and `retire_o` is asserted. An instruction that is not repeating asserts `reloop_o` only when the loop count is nonzero; otherwise it asserts `retire_o`.
- R8: The relooping classes are 0 to 6: send, literal, flags, repeat-load, loop-load, copy-loop and copy-repeat. Clog (7) and any other code (8 to 15) always retire.
- R9: When an instruction completes without repeating and `dec_loop_i` is set, the loop count drops by one, stopping at zero. A repeat pass does not touch the loop count, and neither does a loop-load pass that loads.
- R10: A failing predicate suppresses loads, copies and repeats. Relooping and the decrement-loop effect still apply.
- R11: A copy-loop instruction (class 5) or copy-repeat instruction (class 6) whose predicate holds asserts `copy_req_o`. It drives `copy_word_o` with `data_i`, with its low CNT_W bits replaced by the loop count or the repeat count field.
- R12: The reloop decision uses the loop count held before the cycle. A loop-load or a decrement-loop in the same pass does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_i | input | 1 | One pass of the head instruction happens this cycle |
| cls_i | input | 4 | Decoded instruction class |
| pred_ok_i | input | 1 | Predicate of the instruction holds |
| dec_loop_i | input | 1 | Decrement-loop bit of the instruction |
| sel_i | input | 2 | Counter-load selector |
| lit_i | input | CNT_W | Literal count |
| data_i | input | DATA_W | Current data latch word |
| repeat_o | output | 1 | Instruction runs again in place |
| reloop_o | output | 1 | Instruction is re-enqueued |
| retire_o | output | 1 | Instruction leaves the queue |
| rpt_cnt_o | output | CNT_W | Repeat count field |
| rpt_inf_o | output | 1 | Repeat counter holds infinity |
| loop_cnt_o | output | CNT_W | Loop count |
| copy_req_o | output | 1 | Write `copy_word_o` into the data latch |
| copy_word_o | output | DATA_W | Data word with a counter in its low bits |

## Verification
The bench builds the block with CNT_W=4 and DATA_W=12. With these widths the all-ones count and the truncation of wide data into a counter are easy to reach. The upper data bits are also easy to watch for being kept during a copy.

The directed sequences cover:
- every repeat-load selector, including the reserved one;
- an infinite repeat run;
- a loop count walked down through zero;
- a loop-load that reloops on the old count.

A long pseudo-random stretch then mixes classes, predicates and decrement bits against a behavioural model.

// File: rtl/rlseq_pkg.sv
// Shared class codes and selector codes for the repeat/loop sequencer.
// Assumes the dock decoder maps each instruction to one class code.
package rlseq_pkg;

    typedef enum logic [3:0] {
        IC_SEND    = 4'd0,
        IC_LITERAL = 4'd1,
        IC_FLAGS   = 4'd2,
        IC_REPEAT  = 4'd3,
        IC_LOOP    = 4'd4,
        IC_TAKE_LC = 4'd5,
        IC_TAKE_RC = 4'd6,
        IC_CLOG    = 4'd7,
        IC_OTHER   = 4'd8
    } iclass_e;

    typedef enum logic [1:0] {
        RSEL_DATA = 2'b00,
        RSEL_RSVD = 2'b01,
        RSEL_LIT  = 2'b10,
        RSEL_INF  = 2'b11
    } rsel_e;

    // Classes that may go back into the queue once their repeats are spent.
    function automatic logic is_reloop_class(input logic [3:0] c);
        return (c <= 4'(IC_TAKE_RC));
    endfunction

endpackage

// File: rtl/rlseq_repeat_ctr.sv
// Repeat counter with a separate infinity flag.
// Loads have priority over steps; a step on a zero or infinite count is a no-op.
module rlseq_repeat_ctr #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [1:0]       sel,
    input  logic [CNT_W-1:0] lit,
    input  logic [CNT_W-1:0] data_low,
    input  logic             step_en,
    output logic [CNT_W-1:0] cnt,
    output logic             inf,
    output logic             live
);
    import rlseq_pkg::*;

    // Load, step or hold the repeat count and the infinity flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            inf <= 1'b0;
        end else if (load_en) begin
            case (sel)
                RSEL_DATA: begin cnt <= data_low; inf <= 1'b0; end
                RSEL_LIT:  begin cnt <= lit;      inf <= 1'b0; end
                RSEL_INF:  begin cnt <= '1;       inf <= 1'b1; end
                default:   begin cnt <= cnt;      inf <= inf;  end
            endcase
        end else if (step_en && !inf && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    // A pass may repeat while the count is not used up.
    always_comb live = inf || (cnt != '0);

endmodule

// File: rtl/rlseq_loop_ctr.sv
// Loop counter: loads from data or literal, saturating decrement.
module rlseq_loop_ctr #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             load_lit,
    input  logic [CNT_W-1:0] lit,
    input  logic [CNT_W-1:0] data_low,
    input  logic             dec_en,
    output logic [CNT_W-1:0] cnt,
    output logic             nonzero
);

    // Load or decrement the loop count; decrement stops at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_en) begin
            cnt <= load_lit ? lit : data_low;
        end else if (dec_en && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    // The reloop test uses the count held before this cycle.
    always_comb nonzero = (cnt != '0);

endmodule

// File: rtl/rlseq_decide.sv
// Per-pass decision logic: repeat / reloop / retire and counter enables.
// Purely combinational; assumes counter status reflects the pre-pass state.
module rlseq_decide (
    input  logic       exec,
    input  logic [3:0] cls,
    input  logic       pred_ok,
    input  logic       dec_loop,
    input  logic       rc_live,
    input  logic       lc_nonzero,
    output logic       do_repeat,
    output logic       do_reloop,
    output logic       do_retire,
    output logic       rc_load,
    output logic       rc_step,
    output logic       lc_load,
    output logic       lc_dec,
    output logic       take_lc,
    output logic       take_rc
);
    import rlseq_pkg::*;

    logic live_pass;
    logic done;

    // A pass is live when it executes and its predicate holds.
    always_comb live_pass = exec && pred_ok;

    // Outcome of the pass: repeat first, otherwise reloop or retire.
    always_comb begin
        do_repeat = live_pass && (cls == 4'(IC_SEND)) && rc_live;
        done      = exec && !do_repeat;
        do_reloop = done && is_reloop_class(cls) && lc_nonzero;
        do_retire = done && !do_reloop;
    end

    // Counter enables and copy selects.
    always_comb begin
        rc_load = live_pass && (cls == 4'(IC_REPEAT));
        rc_step = do_repeat;
        lc_load = live_pass && (cls == 4'(IC_LOOP));
        lc_dec  = done && dec_loop && !lc_load;
        take_lc = live_pass && (cls == 4'(IC_TAKE_LC));
        take_rc = live_pass && (cls == 4'(IC_TAKE_RC));
    end

endmodule

// File: rtl/rlseq_top.sv
// Repeat and loop counter sequencer of one dock.
// Assumes exec_i is raised once per pass of the head instruction, with
// class, predicate and fields stable in that cycle. DATA_W must exceed CNT_W.
module rlseq_top #(
    parameter int CNT_W  = 6,
    parameter int DATA_W = 37
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_i,
    input  logic [3:0]        cls_i,
    input  logic              pred_ok_i,
    input  logic              dec_loop_i,
    input  logic [1:0]        sel_i,
    input  logic [CNT_W-1:0]  lit_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              repeat_o,
    output logic              reloop_o,
    output logic              retire_o,
    output logic [CNT_W-1:0]  rpt_cnt_o,
    output logic              rpt_inf_o,
    output logic [CNT_W-1:0]  loop_cnt_o,
    output logic              copy_req_o,
    output logic [DATA_W-1:0] copy_word_o
);

    localparam int UPPER_W = DATA_W - CNT_W;

    logic             rc_live, lc_nz;
    logic             rc_load, rc_step, lc_load, lc_dec, take_lc, take_rc;
    logic [CNT_W-1:0] data_low;
    logic [CNT_W-1:0] copy_val;

    // Low bits of the data word feed both counter loads.
    always_comb data_low = data_i[CNT_W-1:0];

    rlseq_decide u_decide (
        .exec       (exec_i),
        .cls        (cls_i),
        .pred_ok    (pred_ok_i),
        .dec_loop   (dec_loop_i),
        .rc_live    (rc_live),
        .lc_nonzero (lc_nz),
        .do_repeat  (repeat_o),
        .do_reloop  (reloop_o),
        .do_retire  (retire_o),
        .rc_load    (rc_load),
        .rc_step    (rc_step),
        .lc_load    (lc_load),
        .lc_dec     (lc_dec),
        .take_lc    (take_lc),
        .take_rc    (take_rc)
    );

    rlseq_repeat_ctr #(.CNT_W(CNT_W)) u_rpt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (rc_load),
        .sel      (sel_i),
        .lit      (lit_i),
        .data_low (data_low),
        .step_en  (rc_step),
        .cnt      (rpt_cnt_o),
        .inf      (rpt_inf_o),
        .live     (rc_live)
    );

    rlseq_loop_ctr #(.CNT_W(CNT_W)) u_loop (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (lc_load),
        .load_lit (sel_i[0]),
        .lit      (lit_i),
        .data_low (data_low),
        .dec_en   (lc_dec),
        .cnt      (loop_cnt_o),
        .nonzero  (lc_nz)
    );

    // Pick which counter goes into the data latch.
    always_comb begin
        copy_req_o = take_lc || take_rc;
        copy_val   = take_lc ? loop_cnt_o : rpt_cnt_o;
    end

    // Merge the counter into the low bits, keeping the upper data bits.
    generate
        if (UPPER_W > 0) begin : g_merge
            always_comb copy_word_o = {data_i[DATA_W-1:CNT_W], copy_val};
        end else begin : g_narrow
            always_comb copy_word_o = copy_val[DATA_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/rlseq_chk.sv
// Property checker for rlseq_top, attached by bind.
module rlseq_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exec_i,
    input logic [3:0]       cls_i,
    input logic             repeat_o,
    input logic             reloop_o,
    input logic             retire_o,
    input logic [CNT_W-1:0] rpt_cnt_o,
    input logic             rpt_inf_o,
    input logic [CNT_W-1:0] loop_cnt_o,
    input logic             copy_req_o
);

    // R7
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i |-> ($countones({repeat_o, reloop_o, retire_o}) == 1));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |-> !(repeat_o || reloop_o || retire_o || copy_req_o));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> ($stable(rpt_cnt_o) && $stable(rpt_inf_o) && $stable(loop_cnt_o)));

    // R5
    finite_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (repeat_o && !rpt_inf_o) |=> (rpt_cnt_o == CNT_W'($past(rpt_cnt_o) - 1'b1)));

    // R5
    inf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (repeat_o && rpt_inf_o) |=> rpt_inf_o);

    // R12
    reloop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reloop_o |-> (loop_cnt_o != '0));

    // R8
    clog_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && (cls_i >= 4'd7)) |-> retire_o);

    // R9
    repeat_keeps_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        repeat_o |=> $stable(loop_cnt_o));

endmodule

bind rlseq_top rlseq_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_i     (exec_i),
    .cls_i      (cls_i),
    .repeat_o   (repeat_o),
    .reloop_o   (reloop_o),
    .retire_o   (retire_o),
    .rpt_cnt_o  (rpt_cnt_o),
    .rpt_inf_o  (rpt_inf_o),
    .loop_cnt_o (loop_cnt_o),
    .copy_req_o (copy_req_o)
);

// File: tb/rlseq_top_tb_top.sv
`timescale 1ns/1ps
module rlseq_top_tb_top;

    localparam int CNT_W  = 4;
    localparam int DATA_W = 12;
    localparam int MASK   = (1 << CNT_W) - 1;
    localparam int DMASK  = (1 << DATA_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              exec_i = 1'b0;
    logic [3:0]        cls_i = '0;
    logic              pred_ok_i = 1'b0;
    logic              dec_loop_i = 1'b0;
    logic [1:0]        sel_i = '0;
    logic [CNT_W-1:0]  lit_i = '0;
    logic [DATA_W-1:0] data_i = '0;
    logic              repeat_o, reloop_o, retire_o, rpt_inf_o, copy_req_o;
    logic [CNT_W-1:0]  rpt_cnt_o, loop_cnt_o;
    logic [DATA_W-1:0] copy_word_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Behavioural model state
    int m_rc = 0;
    int m_inf = 0;
    int m_lc = 0;

    always #4 clk = ~clk;

    rlseq_top #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .cls_i(cls_i),
        .pred_ok_i(pred_ok_i), .dec_loop_i(dec_loop_i), .sel_i(sel_i),
        .lit_i(lit_i), .data_i(data_i), .repeat_o(repeat_o),
        .reloop_o(reloop_o), .retire_o(retire_o), .rpt_cnt_o(rpt_cnt_o),
        .rpt_inf_o(rpt_inf_o), .loop_cnt_o(loop_cnt_o),
        .copy_req_o(copy_req_o), .copy_word_o(copy_word_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_counters(input string tag);
        check(tag, "rpt_cnt", int'(rpt_cnt_o), m_rc);
        check(tag, "rpt_inf", int'(rpt_inf_o), m_inf);
        check(tag, "loop_cnt", int'(loop_cnt_o), m_lc);
    endtask

    // One cycle: drive, compare decisions, clock, compare counters.
    task automatic step(input string tag, input bit ex, input int cls, input bit pred,
                        input bit dl, input int sel, input int lit, input int data);
        bit e_rep, e_done, e_rel, e_ret, e_cp;
        int e_word;
        @(negedge clk);
        exec_i = ex; cls_i = 4'(cls); pred_ok_i = pred; dec_loop_i = dl;
        sel_i = 2'(sel); lit_i = CNT_W'(lit); data_i = DATA_W'(data);
        #1;
        e_rep  = ex && pred && cls == 0 && (m_inf != 0 || m_rc != 0);
        e_done = ex && !e_rep;
        e_rel  = e_done && cls <= 6 && m_lc != 0;
        e_ret  = e_done && !e_rel;
        e_cp   = ex && pred && (cls == 5 || cls == 6);
        check(tag, "repeat_o", int'(repeat_o), int'(e_rep));
        check(tag, "reloop_o", int'(reloop_o), int'(e_rel));
        check(tag, "retire_o", int'(retire_o), int'(e_ret));
        check(tag, "copy_req_o", int'(copy_req_o), int'(e_cp));
        if (e_cp) begin
            e_word = (data & DMASK & ~MASK) | ((cls == 5) ? m_lc : m_rc);
            check(tag, "copy_word_o", int'(copy_word_o), e_word);
        end
        if (ex && pred && cls == 3) begin
            if (sel == 0) begin m_rc = data & MASK; m_inf = 0; end
            else if (sel == 2) begin m_rc = lit & MASK; m_inf = 0; end
            else if (sel == 3) begin m_rc = MASK; m_inf = 1; end
        end else if (e_rep && m_inf == 0) begin
            m_rc = m_rc - 1;
        end
        if (ex && pred && cls == 4) m_lc = ((sel & 1) != 0) ? (lit & MASK) : (data & MASK);
        else if (e_done && dl && m_lc > 0) m_lc = m_lc - 1;
        @(posedge clk);
        #1;
        check_counters(tag);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit [15:0] lf;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        check_counters("R1");
        check("R1", "decisions", int'({repeat_o, reloop_o, retire_o, copy_req_o}), 0);

        step("R2", 0, 0, 1, 1, 3, 5, 0);
        step("R3", 1, 3, 1, 0, 2, 3, 0);         // literal 3
        for (int i = 0; i < 4; i++) step("R5", 1, 0, 1, 0, 0, 0, 0);
        step("R3", 1, 3, 1, 0, 0, 0, 'hA57);     // data -> 7
        step("R3", 1, 3, 1, 0, 1, 2, 'h3);       // reserved: unchanged
        step("R10", 1, 3, 0, 0, 2, 1, 0);        // predicate fails
        step("R4", 1, 4, 1, 0, 1, 2, 0);         // lc = 2
        step("R12", 1, 4, 1, 0, 0, 0, 'h3C5);    // reloops on old 2, lc = 5
        step("R6", 1, 0, 0, 0, 0, 0, 0);         // send predicate fails
        step("R6", 1, 2, 1, 0, 0, 0, 0);         // flags leaves rc
        step("R9", 1, 2, 1, 1, 0, 0, 0);         // lc 5 -> 4
        step("R9", 1, 0, 1, 1, 0, 0, 0);         // repeat pass keeps lc
        step("R3", 1, 3, 1, 0, 3, 0, 0);         // infinity
        for (int i = 0; i < 3; i++) step("R5", 1, 0, 1, 0, 0, 0, 0);
        step("R11", 1, 6, 1, 0, 0, 0, 'hAB0);
        step("R11", 1, 5, 1, 0, 0, 0, 'hFFF);
        step("R11", 1, 5, 0, 0, 0, 0, 'hFFF);    // no copy when predicate fails
        step("R4", 1, 4, 1, 0, 1, 1, 0);         // lc = 1
        step("R12", 1, 2, 1, 1, 0, 0, 0);        // reloops on 1, lc -> 0
        step("R9", 1, 2, 1, 1, 0, 0, 0);         // retires, lc stays 0
        step("R4", 1, 4, 1, 0, 1, 3, 0);
        step("R8", 1, 7, 1, 0, 0, 0, 0);         // clog retires
        step("R8", 1, 8, 1, 1, 0, 0, 0);
        step("R8", 1, 15, 1, 0, 0, 0, 0);
        step("R10", 1, 1, 0, 1, 0, 0, 0);        // fails but reloops and decrements
        step("R3", 1, 3, 1, 0, 2, 2, 0);
        step("R5", 1, 0, 1, 1, 0, 0, 0);
        step("R5", 1, 0, 1, 1, 0, 0, 0);
        step("R9", 1, 0, 1, 1, 0, 0, 0);         // completion decrements
        lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step("R7", lf[0] | lf[1], int'(lf[5:2]) % 10, lf[6] | lf[7], lf[8],
                 int'(lf[10:9]), int'(lf[14:11]), int'(lf) & DMASK);
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule